// File: doc/BRIEF.md
# Light-Load Pulse-Skip Mode Controller

This block is the cycle-by-cycle mode decision logic of a current-mode step-down converter. It runs in one of two regimes. In fixed-frequency PWM, each oscillator tick turns the high-side switch on, and the PWM current comparator hands the rest of the period to the low-side switch. In the pulse-skipping regime, used at light load, the controller fires single high-side pulses and then lets the output coast with the oscillator gated off. The analog comparators, current sensing and gate drivers sit outside the block. Each one reaches it as a one-bit flag sampled on the system clock.

A mode-select input chooses between the two regimes. When it is low, the converter is held in PWM. When it is high, the controller watches the low-side current for zero crossings. After a run of consecutive crossing cycles, it switches to pulse-skipping. An undervoltage flag at -1.5% of nominal brings it back to PWM at once. Both gate enables are registered behind a dead-time stage, so they are never on together and one idle cycle always separates them.

Top module: `skip_mode_ctrl`

## Requirements
- R1: During reset, both gate enables are low, the skip status is low and the clock-gate output is high.
- R2: In PWM, an oscillator tick turns on the high-side enable, and a PWM comparator trip moves conduction to the low-side enable. While the synchronized mode input is low, skip mode is never entered, however many zero-crossing cycles occur.
- R3: With the synchronized mode input high, skip mode is entered at the oscillator tick that closes the RUN_LEN-th consecutive PWM period containing a zero-crossing pulse (default 8). At that same tick a skip pulse starts. The skip status rises one clock after that tick is sampled.
- R4: A PWM period with no zero-crossing pulse resets the consecutive-period count to zero.
- R5: While counting in PWM, a zero-crossing pulse does not turn off the low-side enable. Negative inductor current is allowed.
- R6: In skip mode, the high-side enable turns on after an oscillator tick. It turns off when either the over-nominal (+1.5%) flag or the skip peak-current flag is raised.
- R7: In skip mode, the low-side enable turns off on a zero-crossing pulse. The block then coasts with both enables low and the clock-gate output low.
- R8: While coasting, the at-or-below-nominal flag sets the clock-gate output high. No new high-side pulse starts until the next oscillator tick.
- R9: The under-nominal (-1.5%) flag in any skip state returns the block to PWM. The skip status falls one clock later.
- R10: The high-side and low-side enables are never high together. A rising edge of either enable is always preceded by one sample in which the other enable is low.
- R11: The mode input passes through a two-flop synchronizer. After a switch to forced PWM during coasting, the clock-gate output rises two clocks later, and skip mode is left at the next oscillator tick.
- R12: Oscillator ticks that arrive while the clock-gate output is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_pfm | input | 1 | Mode select, asynchronous: 1 allows pulse-skipping, 0 forces PWM |
| osc_tick | input | 1 | One-clock pulse at each oscillator rising edge |
| pwm_trip | input | 1 | PWM current comparator has tripped (ends the high-side phase in PWM) |
| zc_flag | input | 1 | Low-side current zero crossing seen |
| ov_hi | input | 1 | Output is above nominal +1.5% |
| uv_lo | input | 1 | Output is below nominal -1.5% |
| at_nom | input | 1 | Output is at or below nominal |
| skip_ilim | input | 1 | Skip peak-current limit reached |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| clk_gate | output | 1 | Oscillator enable (low while coasting) |
| skip_active | output | 1 | Pulse-skipping mode status |

## Verification
The bench keeps its own running model of the zero-crossing run. At every tick it predicts whether skip mode must start, so an off-by-one counter shows up as entry one period early or late. A counter that does not clear on a quiet period shows up as entry within a sweep that places the quiet period at each position. The skip pulse is walked through each of its exits:
- a pulse that ignores the current limit keeps the high side on;
- a controller that acts on ticks while gated starts a pulse in mid-coast;
- a missing synchronizer stage moves the clock-gate release one clock early.

A sample-by-sample monitor catches any overlap of the two enables or a missing dead cycle.

// File: rtl/skip_ctrl_pkg.sv
package skip_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWM_HI   = 3'd0,
    ST_PWM_LO   = 3'd1,
    ST_SK_HI    = 3'd2,
    ST_SK_LO    = 3'd3,
    ST_SK_COAST = 3'd4,
    ST_SK_WAIT  = 3'd5
  } ctrl_state_t;

  function automatic logic is_skip(input ctrl_state_t s);
    return (s == ST_SK_HI) || (s == ST_SK_LO) ||
           (s == ST_SK_COAST) || (s == ST_SK_WAIT);
  endfunction

  function automatic logic wants_high(input ctrl_state_t s);
    return (s == ST_PWM_HI) || (s == ST_SK_HI);
  endfunction

  function automatic logic wants_low(input ctrl_state_t s);
    return (s == ST_PWM_LO) || (s == ST_SK_LO);
  endfunction

  // Oscillator runs unless coasting with pulse-skipping still selected.
  function automatic logic osc_enabled(input ctrl_state_t s, input logic pfm_sel);
    return !((s == ST_SK_COAST) && pfm_sel);
  endfunction

endpackage

// File: rtl/skip_mode_sync.sv
module skip_mode_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/skip_zc_run.sv
module skip_zc_run #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_q,
  input  logic zc_flag,
  input  logic count_en,
  input  logic clr,
  output logic run_hit
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic             zc_seen;
  logic             period_zc;

  assign period_zc = zc_seen | zc_flag;
  assign run_hit   = tick_q & count_en & period_zc & (cnt == LAST) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_seen <= 1'b0;
    end else if (clr || tick_q) begin
      zc_seen <= 1'b0;
    end else if (zc_flag) begin
      zc_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick_q) begin
      if (count_en && period_zc && (cnt != LAST)) cnt <= cnt + 1'b1;
      else                                        cnt <= '0;
    end
  end
endmodule

// File: rtl/skip_gate_dt.sv
module skip_gate_dt (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hs,
  input  logic want_ls,
  output logic hs_en,
  output logic ls_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_en <= 1'b0;
      ls_en <= 1'b0;
    end else begin
      hs_en <= want_hs & ~ls_en;
      ls_en <= want_ls & ~hs_en;
    end
  end
endmodule

// File: rtl/skip_mode_ctrl.sv
module skip_mode_ctrl
  import skip_ctrl_pkg::*;
#(
  parameter int RUN_LEN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pfm,
  input  logic osc_tick,
  input  logic pwm_trip,
  input  logic zc_flag,
  input  logic ov_hi,
  input  logic uv_lo,
  input  logic at_nom,
  input  logic skip_ilim,
  output logic hs_en,
  output logic ls_en,
  output logic clk_gate,
  output logic skip_active
);
  ctrl_state_t st, st_nxt;
  logic mode_s;
  logic tick_q;
  logic run_hit;
  logic in_skip;
  logic st_coast;

  skip_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(mode_pfm), .q_sync(mode_s)
  );

  assign in_skip  = is_skip(st);
  assign st_coast = (st == ST_SK_COAST);
  assign clk_gate = osc_enabled(st, mode_s);
  assign tick_q   = osc_tick & clk_gate;

  skip_zc_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .tick_q(tick_q), .zc_flag(zc_flag),
    .count_en(mode_s), .clr(in_skip), .run_hit(run_hit)
  );

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_PWM_HI: begin
        if (tick_q)        st_nxt = run_hit ? ST_SK_HI : ST_PWM_HI;
        else if (pwm_trip) st_nxt = ST_PWM_LO;
      end
      ST_PWM_LO: begin
        if (tick_q)        st_nxt = run_hit ? ST_SK_HI : ST_PWM_HI;
      end
      default: begin
        if (uv_lo)                  st_nxt = ST_PWM_LO;
        else if (tick_q && !mode_s) st_nxt = ST_PWM_HI;
        else begin
          case (st)
            ST_SK_HI:    if (ov_hi || skip_ilim) st_nxt = ST_SK_LO;
            ST_SK_LO:    if (zc_flag)            st_nxt = ST_SK_COAST;
            ST_SK_COAST: if (at_nom)             st_nxt = ST_SK_WAIT;
            ST_SK_WAIT:  if (tick_q)             st_nxt = ST_SK_HI;
            default:                             st_nxt = ST_PWM_LO;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_PWM_LO;
    else        st <= st_nxt;
  end

  assign skip_active = in_skip;

  skip_gate_dt u_gate (
    .clk(clk), .rst_n(rst_n),
    .want_hs(wants_high(st)), .want_ls(wants_low(st)),
    .hs_en(hs_en), .ls_en(ls_en)
  );
endmodule

// File: rtl/skip_mode_ctrl_sva.sv
module skip_mode_ctrl_sva (
  input logic clk,
  input logic rst_n,
  input logic hs_en,
  input logic ls_en,
  input logic skip_active,
  input logic mode_s,
  input logic run_hit,
  input logic tick_q,
  input logic st_coast,
  input logic uv_lo
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en)); // R10
  AST_DEAD_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && !$past(hs_en)) |-> !$past(ls_en)); // R10
  AST_DEAD_LS: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_en && !$past(ls_en)) |-> !$past(hs_en)); // R10
  AST_FORCED_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && !skip_active) |=> !skip_active); // R2
  AST_ENTRY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skip_active) |-> $past(run_hit)); // R3
  AST_COAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    st_coast |-> !hs_en); // R7
  AST_UV_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_active && uv_lo) |=> !skip_active); // R9
  AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_active && !mode_s && tick_q) |=> !skip_active); // R11
endmodule

bind skip_mode_ctrl skip_mode_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .ls_en(ls_en),
  .skip_active(skip_active), .mode_s(mode_s), .run_hit(run_hit),
  .tick_q(tick_q), .st_coast(st_coast), .uv_lo(uv_lo)
);

// File: tb/sim_skip_mode_ctrl.sv
`timescale 1ns/1ps
module sim_skip_mode_ctrl;
  localparam int RUN_LEN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pfm = 1'b1, osc_tick = 1'b0, pwm_trip = 1'b0, zc_flag = 1'b0;
  logic ov_hi = 1'b0, uv_lo = 1'b0, at_nom = 1'b0, skip_ilim = 1'b0;
  logic hs_en, ls_en, clk_gate, skip_active;

  int n_checks = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  int b_run = 0;
  bit b_prev_zc = 1'b0;
  bit b_mode = 1'b1;
  logic p_hs = 1'b0, p_ls = 1'b0;

  always #10 clk = ~clk;

  skip_mode_ctrl #(.RUN_LEN(RUN_LEN), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_pfm(mode_pfm), .osc_tick(osc_tick),
    .pwm_trip(pwm_trip), .zc_flag(zc_flag), .ov_hi(ov_hi), .uv_lo(uv_lo),
    .at_nom(at_nom), .skip_ilim(skip_ilim), .hs_en(hs_en), .ls_en(ls_en),
    .clk_gate(clk_gate), .skip_active(skip_active)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end (actual cycles %0d, expected < 150000)", cyc_cnt);
      finish_run();
    end
  end

  // R10 monitor: no overlap, one dead sample before any rising enable
  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if ((hs_en && ls_en) || (hs_en && !p_hs && p_ls) || (ls_en && !p_ls && p_hs)) begin
        n_fail++;
        $display("FAIL R10 dead time: actual hs=%0b ls=%0b prev hs=%0b ls=%0b, expected no overlap",
                 hs_en, ls_en, p_hs, p_ls);
      end
    end
    p_hs = hs_en;
    p_ls = ls_en;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic pwm_cycle(input bit zc, output bit entered);
    osc_tick = 1'b1; cyc(1); osc_tick = 1'b0;
    if (b_mode && b_prev_zc) b_run++; else b_run = 0;
    b_prev_zc = 1'b0;
    entered = (b_run >= RUN_LEN);
    chk("R3 skip entry on run length", skip_active, entered);
    if (entered) begin
      b_run = 0;
      return;
    end
    cyc(3);
    chk("R2 hs on after tick", hs_en, 1'b1);
    pwm_trip = 1'b1; cyc(1); pwm_trip = 1'b0; cyc(2);
    chk("R2 ls on after trip", ls_en, 1'b1);
    chk("R2 hs off after trip", hs_en, 1'b0);
    if (zc) begin
      zc_flag = 1'b1; cyc(1); zc_flag = 1'b0;
      b_prev_zc = 1'b1;
      cyc(1);
      chk("R5 ls held after zero crossing", ls_en, 1'b1);
    end
    cyc(2);
  endtask

  task automatic run_to_skip();
    bit ent = 1'b0;
    for (int i = 0; i < RUN_LEN + 4 && !ent; i++) pwm_cycle(1'b1, ent);
    chk("R3 skip reached", ent, 1'b1);
  endtask

  task automatic uv_exit();
    uv_lo = 1'b1; cyc(1); uv_lo = 1'b0;
    chk("R9 undervoltage leaves skip", skip_active, 1'b0);
    b_run = 0; b_prev_zc = 1'b0;
    cyc(3);
  endtask

  initial begin
    bit ent;
    cyc(2);
    chk("R1 reset hs", hs_en, 1'b0);
    chk("R1 reset ls", ls_en, 1'b0);
    chk("R1 reset skip", skip_active, 1'b0);
    chk("R1 reset clk_gate", clk_gate, 1'b1);
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R3 / R5: plain run of crossing periods
    run_to_skip();
    cyc(2);
    chk("R6 skip pulse hs on", hs_en, 1'b1);
    ov_hi = 1'b1; cyc(1); ov_hi = 1'b0; cyc(2);
    chk("R6 ov ends hs", hs_en, 1'b0);
    chk("R7 ls after skip pulse", ls_en, 1'b1);
    zc_flag = 1'b1; cyc(1); zc_flag = 1'b0;
    chk("R7 coast gates clock", clk_gate, 1'b0);
    chk("R7 still in skip", skip_active, 1'b1);
    cyc(1);
    chk("R7 ls off on zero crossing", ls_en, 1'b0);
    chk("R7 hs off in coast", hs_en, 1'b0);
    osc_tick = 1'b1; cyc(1); osc_tick = 1'b0; cyc(2);
    chk("R12 gated tick ignored hs", hs_en, 1'b0);
    chk("R12 gated tick ignored gate", clk_gate, 1'b0);
    at_nom = 1'b1; cyc(1); at_nom = 1'b0;
    chk("R8 clock ungated at nominal", clk_gate, 1'b1);
    cyc(3);
    chk("R8 waits for tick", hs_en, 1'b0);
    osc_tick = 1'b1; cyc(1); osc_tick = 1'b0; cyc(1);
    chk("R8 pulse on tick", hs_en, 1'b1);
    skip_ilim = 1'b1; cyc(1); skip_ilim = 1'b0; cyc(1);
    chk("R6 current limit ends hs", hs_en, 1'b0);
    uv_exit();

    // R4: quiet period at each position of a run
    for (int gap = 0; gap <= RUN_LEN; gap++) begin
      ent = 1'b0;
      for (int i = 0; i < RUN_LEN + 4; i++) begin
        if (!ent) pwm_cycle(i != gap, ent);
      end
      if (ent) uv_exit();
    end
    // R4: flush any partial run before the next test
    pwm_cycle(1'b0, ent);
    pwm_cycle(1'b0, ent);

    // R11: switch to forced PWM while coasting
    run_to_skip();
    cyc(2);
    ov_hi = 1'b1; cyc(1); ov_hi = 1'b0; cyc(2);
    zc_flag = 1'b1; cyc(1); zc_flag = 1'b0;
    chk("R11 coasting before switch", clk_gate, 1'b0);
    mode_pfm = 1'b0; b_mode = 1'b0;
    cyc(1);
    chk("R11 sync latency stage one", clk_gate, 1'b0);
    cyc(1);
    chk("R11 gate released after sync", clk_gate, 1'b1);
    chk("R11 skip held until tick", skip_active, 1'b1);
    cyc(2);
    chk("R11 skip held without tick", skip_active, 1'b1);
    osc_tick = 1'b1; cyc(1); osc_tick = 1'b0;
    chk("R11 skip left on tick", skip_active, 1'b0);
    b_run = 0; b_prev_zc = 1'b0;
    cyc(3);

    // R2: forced PWM ignores long crossing runs
    for (int i = 0; i < 2 * RUN_LEN; i++) pwm_cycle(1'b1, ent);
    chk("R2 no skip in forced PWM", skip_active, 1'b0);

    cyc(4);
    finish_run();
  end
endmodule